// File: doc/BRIEF.md
# Eight-bit ALU with flag update stage

This block is the arithmetic-logic datapath of a small 8-bit RISC core. It takes two operands, a carry-in and a 4-bit operation select. In the same cycle it produces the 8-bit result, the candidate value of every status flag and a write enable for each flag. One flag register sits behind this combinational path. On a clock edge where `commit` is high, it loads each flag whose write enable is set and keeps the others.

The operations are add and subtract, each with or without carry, the three bitwise logic operations, one's complement, negate, increment, decrement, four shift/rotate forms and nibble swap. Each operation writes only its own set of flags. A flag it does not write keeps its stored value, and `flag_next` shows that stored value for it. The previous zero flag, read from the register, lets subtract-with-carry chain across the bytes of a multi-byte compare.

The flag vector uses these bit positions everywhere: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S), bit 5 half-carry (H). In the requirements, "result zero" means the 8-bit result equals 0x00 and N means result bit 7.

Top module: `byte_alu_core`

## Requirements
- R1: Opcode 0 (add) returns a+b and opcode 1 (add with carry) returns a+b+carry_in. Both write all six flags: C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow and Z means result zero.
- R2: Opcode 2 (subtract) returns a-b and opcode 3 (subtract with carry) returns a-b-carry_in. Both write all six flags: C is the borrow out of bit 7, H is the borrow from bit 4 into bit 3 and V is signed overflow. For opcode 3, Z is set only if the result is zero and the stored Z is already 1.
- R3: Opcodes 4, 5 and 6 (AND, OR, XOR of a and b) write only Z, N, V and S, and V is cleared. The stored C and H are kept.
- R4: Opcode 7 (one's complement) returns 0xFF-a. It sets C to 1, clears V, writes Z, N and S, and keeps H.
- R5: Opcode 8 (negate) returns 0x00-a and writes all six flags. C is 1 when a is nonzero, H is 1 when a[3:0] is nonzero and V is 1 only for a=0x80.
- R6: Opcode 9 (increment) returns a+1 and sets V only for a=0x7F. Opcode 10 (decrement) returns a-1 and sets V only for a=0x80. Both write only Z, N, V and S, so C and H are kept.
- R7: The shift and rotate opcodes write C, Z, N, V and S, and keep H. In each case V = N XOR the new C.
  - Opcode 11 (logical shift right) puts 0 in bit 7 and bit 0 in C.
  - Opcode 12 (rotate right) puts carry_in in bit 7 and bit 0 in C.
  - Opcode 13 (rotate left) puts carry_in in bit 0 and bit 7 in C.
  - Opcode 14 (arithmetic shift right) keeps bit 7, shifts bits 7..1 into 6..0 and puts bit 0 in C.
- R8: Opcode 15 (swap) exchanges the upper and lower nibbles of a and writes no flag.
- R9: Whenever S is written, its new value is the new N XOR the new V.
- R10: `flag_wen` has exactly the bits named in R1..R8 for the selected opcode. For each flag whose enable is clear, `flag_next` equals the stored flag.
- R11: `flags` is cleared to zero on a clock edge with rst_n low, even when commit is high. It takes the value of `flag_next` on a clock edge with commit high, and holds its value on an edge with commit low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Synchronous reset, active low |
| operand_a | input | 8 | First operand; the only operand of the unary operations |
| operand_b | input | 8 | Second operand of the two-operand operations |
| carry_in | input | 1 | Carry used by add/subtract with carry and by the rotates |
| op_sel | input | 4 | Operation select, encoded as listed in R1..R8 |
| commit | input | 1 | Load the written flags into the register on the next edge |
| result | output | 8 | Operation result (combinational) |
| flag_next | output | 6 | Flag values after this operation (combinational) |
| flag_wen | output | 6 | Per-flag write enables of the selected operation |
| flags | output | 6 | Stored flags |

## Verification
`result`, `flag_wen` and `flag_next` pass through no register. They are due in the same cycle the operands change, so the bench samples them one nanosecond after it drives new inputs. The stored `flags` pass through exactly one register. They are due after the first rising edge at which `commit` was high, and the bench reads them one nanosecond after that edge, before it changes any input. The combinational sweep covers every operation, every value of `operand_a`, sixteen values of `operand_b` and both carry values. A stepped phase then checks the register, including held flags, chained subtract-with-carry compares and a reset that arrives while `commit` is high.

// File: rtl/byte_alu_pkg.sv
// byte_alu_pkg: shared widths, operation codes and flag bit positions
// for the byte ALU. Assumes an even data width so that halves exist.
package byte_alu_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned FLAG_CNT = 6;

    // Flag bit positions inside every flag vector of the block.
    localparam int unsigned FL_C = 0;
    localparam int unsigned FL_Z = 1;
    localparam int unsigned FL_N = 2;
    localparam int unsigned FL_V = 3;
    localparam int unsigned FL_S = 4;
    localparam int unsigned FL_H = 5;

    typedef logic [FLAG_CNT-1:0] flag_vec_t;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_COM  = 4'd7,
        OP_NEG  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_LSR  = 4'd11,
        OP_ROR  = 4'd12,
        OP_ROL  = 4'd13,
        OP_ASR  = 4'd14,
        OP_SWAP = 4'd15
    } alu_op_e;

    // True for the operations whose result comes from the adder.
    function automatic logic uses_adder(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_NEG) || (op == OP_INC) ||
               (op == OP_DEC);
    endfunction

endpackage

// File: rtl/byte_alu_arith.sv
// byte_alu_arith: one shared adder serving add, subtract, negate,
// increment and decrement. Subtraction adds the inverted operand with
// an inverted carry-in, and the carry outs are inverted back into
// borrows. Assumes W is even (half-carry taken out of the low half).
module byte_alu_arith
    import byte_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         carry_in,
    input  alu_op_e      op,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         half_out,
    output logic         ovf_out
);

    localparam int unsigned HW = W / 2;

    logic [W-1:0] x_opnd;
    logic [W-1:0] y_opnd;
    logic         cin_eff;
    logic         borrow_mode;
    logic [W:0]   full_sum;
    logic [HW:0]  low_sum;

    // Choose adder operands and carry-in for the selected operation.
    always_comb begin
        x_opnd      = a;
        y_opnd      = b;
        cin_eff     = 1'b0;
        borrow_mode = 1'b0;
        unique case (op)
            OP_ADC: cin_eff = carry_in;
            OP_SUB: begin
                y_opnd      = ~b;
                cin_eff     = 1'b1;
                borrow_mode = 1'b1;
            end
            OP_SBC: begin
                y_opnd      = ~b;
                cin_eff     = ~carry_in;
                borrow_mode = 1'b1;
            end
            OP_NEG: begin
                x_opnd      = '0;
                y_opnd      = ~a;
                cin_eff     = 1'b1;
                borrow_mode = 1'b1;
            end
            OP_INC: begin
                y_opnd  = '0;
                cin_eff = 1'b1;
            end
            OP_DEC: y_opnd = '1;
            default: ;
        endcase
    end

    assign full_sum  = {1'b0, x_opnd} + {1'b0, y_opnd} + {{W{1'b0}}, cin_eff};
    assign low_sum   = {1'b0, x_opnd[HW-1:0]} + {1'b0, y_opnd[HW-1:0]}
                     + {{HW{1'b0}}, cin_eff};
    assign sum       = full_sum[W-1:0];
    assign carry_out = full_sum[W] ^ borrow_mode;
    assign half_out  = low_sum[HW] ^ borrow_mode;
    // Overflow: equal operand signs, result sign differs from them.
    assign ovf_out   = (x_opnd[W-1] == y_opnd[W-1]) && (sum[W-1] != x_opnd[W-1]);

endmodule

// File: rtl/byte_alu_bitops.sv
// byte_alu_bitops: bitwise logic, one's complement, the four shift and
// rotate forms and half swap. Also returns the bit shifted out, which
// becomes the carry of the shift operations. Assumes W is even.
module byte_alu_bitops
    import byte_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         carry_in,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         shift_out
);

    localparam int unsigned HW = W / 2;

    // Form the non-adder result and the shifted-out bit.
    always_comb begin
        res       = a;
        shift_out = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_COM:  res = ~a;
            OP_LSR: begin
                res       = {1'b0, a[W-1:1]};
                shift_out = a[0];
            end
            OP_ROR: begin
                res       = {carry_in, a[W-1:1]};
                shift_out = a[0];
            end
            OP_ROL: begin
                res       = {a[W-2:0], carry_in};
                shift_out = a[W-1];
            end
            OP_ASR: begin
                res       = {a[W-1], a[W-1:1]};
                shift_out = a[0];
            end
            OP_SWAP: res = {a[HW-1:0], a[W-1:HW]};
            default: ;
        endcase
    end

endmodule

// File: rtl/byte_alu_flagsel.sv
// byte_alu_flagsel: picks the result source, derives fresh flag values
// and the per-operation write enables, and shows the stored value for
// every flag that the operation does not write. Assumes the stored
// flags come from byte_alu_flagreg.
module byte_alu_flagsel
    import byte_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   add_sum,
    input  logic           add_c,
    input  logic           add_h,
    input  logic           add_v,
    input  logic [W-1:0]   bit_res,
    input  logic           bit_c,
    input  flag_vec_t      flags_q,
    output logic [W-1:0]   result,
    output flag_vec_t      flag_next,
    output flag_vec_t      flag_wen
);

    flag_vec_t fresh;
    logic      res_zero;
    logic      res_neg;

    assign result   = uses_adder(op) ? add_sum : bit_res;
    assign res_zero = (result == '0);
    assign res_neg  = result[W-1];

    // Compute the value each flag would take if written.
    always_comb begin
        fresh       = '0;
        fresh[FL_N] = res_neg;
        fresh[FL_H] = add_h;
        fresh[FL_Z] = (op == OP_SBC) ? (res_zero & flags_q[FL_Z]) : res_zero;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: begin
                fresh[FL_C] = add_c;
                fresh[FL_V] = add_v;
            end
            OP_COM: begin
                fresh[FL_C] = 1'b1;
                fresh[FL_V] = 1'b0;
            end
            OP_LSR, OP_ROR, OP_ROL, OP_ASR: begin
                fresh[FL_C] = bit_c;
                fresh[FL_V] = res_neg ^ bit_c;
            end
            default: begin
                fresh[FL_C] = 1'b0;
                fresh[FL_V] = 1'b0;
            end
        endcase
        fresh[FL_S] = fresh[FL_N] ^ fresh[FL_V];
    end

    // Decide which flags the selected operation writes.
    always_comb begin
        flag_wen = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
                flag_wen = '1;
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin
                flag_wen[FL_Z] = 1'b1;
                flag_wen[FL_N] = 1'b1;
                flag_wen[FL_V] = 1'b1;
                flag_wen[FL_S] = 1'b1;
            end
            OP_COM, OP_LSR, OP_ROR, OP_ROL, OP_ASR: begin
                flag_wen       = '1;
                flag_wen[FL_H] = 1'b0;
            end
            default: flag_wen = '0;
        endcase
    end

    // Unwritten flags pass their stored value through.
    for (genvar gi = 0; gi < FLAG_CNT; gi++) begin : g_merge
        assign flag_next[gi] = flag_wen[gi] ? fresh[gi] : flags_q[gi];
    end

endmodule

// File: rtl/byte_alu_flagreg.sv
// byte_alu_flagreg: the stored status flags. Each bit loads its next
// value when commit is high and its write enable is set; reset is
// synchronous and active low and wins over commit.
module byte_alu_flagreg
    import byte_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      commit,
    input  flag_vec_t flag_next,
    input  flag_vec_t flag_wen,
    output flag_vec_t flags_q
);

    for (genvar gi = 0; gi < FLAG_CNT; gi++) begin : g_bit
        // Hold or load one flag bit per clock edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[gi] <= 1'b0;
            end else if (commit && flag_wen[gi]) begin
                flags_q[gi] <= flag_next[gi];
            end
        end
    end

endmodule

// File: rtl/byte_alu_core.sv
// byte_alu_core: top of the byte ALU. The result and flag candidates
// are combinational; only the flag register is clocked. Assumes the
// decoder drives op_sel with the operation codes of byte_alu_pkg.
module byte_alu_core
    import byte_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        operand_a,
    input  logic [W-1:0]        operand_b,
    input  logic                carry_in,
    input  logic [3:0]          op_sel,
    input  logic                commit,
    output logic [W-1:0]        result,
    output logic [FLAG_CNT-1:0] flag_next,
    output logic [FLAG_CNT-1:0] flag_wen,
    output logic [FLAG_CNT-1:0] flags
);

    alu_op_e      op;
    logic [W-1:0] add_sum;
    logic         add_c;
    logic         add_h;
    logic         add_v;
    logic [W-1:0] bit_res;
    logic         bit_c;
    flag_vec_t    flags_q;

    assign op    = alu_op_e'(op_sel);
    assign flags = flags_q;

    byte_alu_arith #(.W(W)) u_arith (
        .a         (operand_a),
        .b         (operand_b),
        .carry_in  (carry_in),
        .op        (op),
        .sum       (add_sum),
        .carry_out (add_c),
        .half_out  (add_h),
        .ovf_out   (add_v)
    );

    byte_alu_bitops #(.W(W)) u_bitops (
        .a         (operand_a),
        .b         (operand_b),
        .carry_in  (carry_in),
        .op        (op),
        .res       (bit_res),
        .shift_out (bit_c)
    );

    byte_alu_flagsel #(.W(W)) u_flagsel (
        .op        (op),
        .add_sum   (add_sum),
        .add_c     (add_c),
        .add_h     (add_h),
        .add_v     (add_v),
        .bit_res   (bit_res),
        .bit_c     (bit_c),
        .flags_q   (flags_q),
        .result    (result),
        .flag_next (flag_next),
        .flag_wen  (flag_wen)
    );

    byte_alu_flagreg u_flagreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .flag_next (flag_next),
        .flag_wen  (flag_wen),
        .flags_q   (flags_q)
    );

endmodule

// File: rtl/byte_alu_checker.sv
// byte_alu_checker: temporal properties of the flag register and the
// zero flag, attached to byte_alu_core by the bind below.
module byte_alu_checker
    import byte_alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          op_sel,
    input logic                commit,
    input logic [W-1:0]        result,
    input logic [FLAG_CNT-1:0] flag_next,
    input logic [FLAG_CNT-1:0] flag_wen,
    input logic [FLAG_CNT-1:0] flags
);

    assert_swap_keeps_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_sel == OP_SWAP) |=> $stable(flags));

    assert_logic_keeps_c_h_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR))
        |=> (flags[FL_C] == $past(flags[FL_C])) && (flags[FL_H] == $past(flags[FL_H]))
            && !flags[FL_V]);

    assert_complement_sets_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_sel == OP_COM) |=> (flags[FL_C] && !flags[FL_V]));

    assert_incdec_keep_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (op_sel == OP_INC || op_sel == OP_DEC))
        |=> $stable(flags[FL_C]) && $stable(flags[FL_H]));

    assert_sign_matches_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && flag_wen[FL_S]) |=> (flags[FL_S] == (flags[FL_N] ^ flags[FL_V])));

    assert_idle_holds_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(flags));

    assert_zero_tracks_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wen[FL_Z] && op_sel != OP_SBC) |-> (flag_next[FL_Z] == (result == '0)));

endmodule

bind byte_alu_core byte_alu_checker #(.W(W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .commit    (commit),
    .result    (result),
    .flag_next (flag_next),
    .flag_wen  (flag_wen),
    .flags     (flags)
);

// File: tb/test_byte_alu_core.sv
// test_byte_alu_core: combinational sweep of every operation against an
// arithmetic reference, then stepped checks of the flag register.
module test_byte_alu_core;

    localparam int FC = 0;
    localparam int FZ = 1;
    localparam int FN = 2;
    localparam int FV = 3;
    localparam int FS = 4;
    localparam int FH = 5;
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic       cin = 1'b0;
    logic [3:0] opsel = '0;
    logic       commit = 1'b0;
    logic [7:0] result;
    logic [5:0] flag_next;
    logic [5:0] flag_wen;
    logic [5:0] flags;

    int         errors = 0;
    int         checks = 0;
    int         cyc = 0;
    logic [5:0] fq_m = '0;

    byte_alu_core i_byte_alu_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_a (opa),
        .operand_b (opb),
        .carry_in  (cin),
        .op_sel    (opsel),
        .commit    (commit),
        .result    (result),
        .flag_next (flag_next),
        .flag_wen  (flag_wen),
        .flags     (flags)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s op=%0d a=%02h b=%02h cin=%0d actual=%0h expected=%0h",
                     req, what, opsel, opa, opb, cin, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0, 1:          return "R1";
            2, 3:          return "R2";
            4, 5, 6:       return "R3";
            7:             return "R4";
            8:             return "R5";
            9, 10:         return "R6";
            11, 12, 13, 14: return "R7";
            default:       return "R8";
        endcase
    endfunction

    function automatic int sgn(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    // Reference model computed from the requirements.
    task automatic model(input int op, input int a, input int b, input int ci,
                         input logic [5:0] fq, output logic [7:0] r,
                         output logic [5:0] we, output logic [5:0] nx);
        int res, c, h, v, z, n, s, sv, c0;
        logic [5:0] fr;
        res = 0; c = 0; h = 0; v = 0; we = 6'b000000;
        case (op)
            0, 1: begin
                c0 = (op == 1) ? ci : 0;
                res = (a + b + c0) % 256;
                c = ((a + b + c0) > 255) ? 1 : 0;
                h = (((a % 16) + (b % 16) + c0) > 15) ? 1 : 0;
                sv = sgn(a) + sgn(b) + c0;
                v = (sv > 127 || sv < -128) ? 1 : 0;
                we = 6'b111111;
            end
            2, 3: begin
                c0 = (op == 3) ? ci : 0;
                res = (a - b - c0 + 512) % 256;
                c = ((a - b - c0) < 0) ? 1 : 0;
                h = (((a % 16) - (b % 16) - c0) < 0) ? 1 : 0;
                sv = sgn(a) - sgn(b) - c0;
                v = (sv > 127 || sv < -128) ? 1 : 0;
                we = 6'b111111;
            end
            4: begin res = a & b; we = 6'b011110; end
            5: begin res = a | b; we = 6'b011110; end
            6: begin res = a ^ b; we = 6'b011110; end
            7: begin res = 255 - a; c = 1; we = 6'b011111; end
            8: begin
                res = (256 - a) % 256;
                c = (a != 0) ? 1 : 0;
                h = ((a % 16) != 0) ? 1 : 0;
                v = (a == 128) ? 1 : 0;
                we = 6'b111111;
            end
            9:  begin res = (a + 1) % 256;   v = (a == 127) ? 1 : 0; we = 6'b011110; end
            10: begin res = (a + 255) % 256; v = (a == 128) ? 1 : 0; we = 6'b011110; end
            11: begin res = a / 2;                              c = a % 2;   we = 6'b011111; end
            12: begin res = a / 2 + ci * 128;                   c = a % 2;   we = 6'b011111; end
            13: begin res = (a * 2) % 256 + ci;                 c = a / 128; we = 6'b011111; end
            14: begin res = a / 2 + ((a >= 128) ? 128 : 0);     c = a % 2;   we = 6'b011111; end
            default: begin res = (a % 16) * 16 + a / 16; we = 6'b000000; end
        endcase
        n = (res >= 128) ? 1 : 0;
        if (op >= 11 && op <= 14) v = n ^ c;
        z = (res == 0) ? 1 : 0;
        if (op == 3) z = z & int'(fq[FZ]);
        s = n ^ v;
        fr = '0;
        fr[FC] = c[0]; fr[FZ] = z[0]; fr[FN] = n[0];
        fr[FV] = v[0]; fr[FS] = s[0]; fr[FH] = h[0];
        for (int i = 0; i < 6; i++) nx[i] = we[i] ? fr[i] : fq[i];
        r = res[7:0];
    endtask

    // Drive one operation at a falling edge, check the register after the edge.
    task automatic step(input int op, input int a, input int b, input int ci, input bit cm);
        logic [7:0] r;
        logic [5:0] we, nx;
        @(negedge clk);
        opsel = op[3:0]; opa = a[7:0]; opb = b[7:0]; cin = ci[0]; commit = cm;
        #1;
        model(op, a, b, ci, fq_m, r, we, nx);
        chk(req_of(op), "comb result", int'(result), int'(r));
        if (cm) fq_m = nx;
        @(posedge clk);
        #1;
        chk("R11", "stored flags", int'(flags), int'(fq_m));
        commit = 1'b0;
    endtask

    initial begin
        logic [7:0]  r;
        logic [5:0]  we, nx;
        logic [31:0] seed;

        // Reset with commit high: reset must win (R11).
        opsel = 4'd0; opa = 8'h80; opb = 8'h80; commit = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset flags", int'(flags), 0);
        commit = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Combinational sweep, register untouched.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 17) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        opsel = op[3:0]; opa = a[7:0]; opb = b[7:0]; cin = ci[0];
                        #1;
                        model(op, a, b, ci, fq_m, r, we, nx);
                        chk(req_of(op), "result", int'(result), int'(r));
                        chk("R10", "write enables", int'(flag_wen), int'(we));
                        chk(req_of(op), "next flags", int'(flag_next), int'(nx));
                        if (we[FS]) chk("R9", "sign flag", int'(flag_next[FS]), int'(nx[FS]));
                    end
                end
            end
        end
        @(negedge clk);
        chk("R11", "flags held without commit", int'(flags), int'(fq_m));

        // Two-byte compare, equal values: Z survives the chain (R2).
        step(2, 8'h34, 8'h34, 0, 1'b1);
        chk("R2", "low byte Z", int'(flags[FZ]), 1);
        step(3, 8'h12, 8'h12, int'(flags[FC]), 1'b1);
        chk("R2", "chained Z equal", int'(flags[FZ]), 1);
        // Low bytes differ, high bytes equal: Z stays clear (R2).
        step(2, 8'h35, 8'h34, 0, 1'b1);
        step(3, 8'h12, 8'h12, int'(flags[FC]), 1'b1);
        chk("R2", "chained Z after nonzero low", int'(flags[FZ]), 0);
        // Carry set, then logic op keeps it (R3); swap keeps all (R8).
        step(2, 8'h00, 8'h01, 0, 1'b1);
        chk("R2", "borrow C", int'(flags[FC]), 1);
        step(4, 8'h0F, 8'hF0, 0, 1'b1);
        chk("R3", "C kept by AND", int'(flags[FC]), 1);
        step(15, 8'hA5, 8'h00, 0, 1'b1);
        chk("R8", "swap kept flags", int'(flags), int'(fq_m));

        // Reset in mid-run with commit high (R11).
        @(negedge clk);
        rst_n = 1'b0; commit = 1'b1; opsel = 4'd8; opa = 8'h80;
        @(posedge clk);
        #1;
        chk("R11", "mid-run reset", int'(flags), 0);
        fq_m = '0;
        @(negedge clk);
        rst_n = 1'b1; commit = 1'b0;

        // Pseudo-random operation stream with occasional idle cycles.
        seed = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            seed ^= seed << 13;
            seed ^= seed >> 17;
            seed ^= seed << 5;
            step(int'(seed[3:0]), int'(seed[11:4]), int'(seed[19:12]),
                 int'(seed[20]), seed[22:21] != 2'b00);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule